// File: doc/BRIEF.md
# Capture/Reload/Baud Timer

This block is a 16-bit up-counter with a 16-bit capture/reload register and a separate trigger input. It works as an auto-reload timer, as a capture timer, or as a baud-rate generator that supplies transmit and receive clock ticks to a serial port. The mode, the run gate, the count source and the trigger enable come in as static control inputs. Two sticky status flags report counter wrap and trigger events, and each has its own clear input.

The count source is either a prescaled internal tick or falling edges on an external count pin. The internal tick divides the block clock by 12 in the two timer modes and by 2 in baud mode. The external count pin and the trigger pin each pass through a two-flop synchroniser before edge detection. Every output comes from a register.

Top module: `crb_timer`

## Requirements
- R1: After reset, count_o, rld_o, both flags and all three tick outputs are 0.
- R2: Mode precedence works as follows. If tx_baud_i or rx_baud_i is 1, the block is in baud mode and cap_sel_i has no effect. Otherwise cap_sel_i=1 selects capture mode and cap_sel_i=0 selects auto-reload mode.
- R3: With ext_src_i=0, the counter advances once every 12 clocks in the timer modes and once every 2 clocks in baud mode, counted from the cycle run_i rises. With ext_src_i=1, the counter advances once per falling edge on cnt_pin_i. Through the synchroniser, a pin that goes low before clock edge k is counted at edge k+2.
- R4: While run_i=0, the counter does not advance and the prescaler restarts from zero.
- R5: In auto-reload mode, an advance from 0xFFFF loads rld_o into the counter and sets ovf_flag_o.
- R6: A falling edge on trig_pin_i with trig_en_i=1 sets trig_flag_o in any mode, and in auto-reload mode it also loads rld_o into the counter. It takes effect at edge k+2 when the pin goes low before edge k, independent of run_i. With trig_en_i=0 the trigger pin has no effect.
- R7: In capture mode, a trigger copies the current count into rld_o and the counter keeps advancing. An advance from 0xFFFF wraps to 0 and sets ovf_flag_o.
- R8: In baud mode, an advance from 0xFFFF reloads from rld_o without setting ovf_flag_o. tx_tick_o pulses on that wrap when tx_baud_i=1, and rx_tick_o pulses when rx_baud_i=1.
- R9: ovf_clr_i and trig_clr_i clear their flags. A set in the same cycle wins over the clear.
- R10: cnt_wr_i loads cnt_data_i into the counter and takes priority over any count or reload. rld_wr_i loads rld_data_i into the reload register and takes priority over a capture.
- R11: ovf_tick_o is high for exactly one cycle per wrap in every mode, in the same cycle the new count appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock (oscillator) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Count enable |
| ext_src_i | input | 1 | 1: count cnt_pin_i falling edges; 0: internal prescaler |
| trig_en_i | input | 1 | Enables the trigger pin |
| cap_sel_i | input | 1 | 1: capture, 0: auto-reload (when not in baud mode) |
| tx_baud_i | input | 1 | Wrap drives transmit tick; forces baud mode |
| rx_baud_i | input | 1 | Wrap drives receive tick; forces baud mode |
| cnt_pin_i | input | 1 | External count pin, asynchronous |
| trig_pin_i | input | 1 | External trigger pin, asynchronous |
| cnt_wr_i | input | 1 | Counter write strobe |
| cnt_data_i | input | 16 | Counter write data |
| rld_wr_i | input | 1 | Capture/reload register write strobe |
| rld_data_i | input | 16 | Capture/reload register write data |
| ovf_clr_i | input | 1 | Clears ovf_flag_o |
| trig_clr_i | input | 1 | Clears trig_flag_o |
| count_o | output | 16 | Current count |
| rld_o | output | 16 | Capture/reload register |
| ovf_flag_o | output | 1 | Sticky wrap flag (timer modes) |
| trig_flag_o | output | 1 | Sticky trigger flag |
| ovf_tick_o | output | 1 | One-cycle wrap pulse |
| tx_tick_o | output | 1 | Transmit clock tick (baud mode) |
| rx_tick_o | output | 1 | Receive clock tick (baud mode) |

## Verification
The bench targets the cases where the block changes its behaviour: a set capture bit while a baud select is active, a trigger while stopped, and a trigger with its enable off. If the capture bit were not ignored in baud mode, rld_o would take the live count. A design that set the wrap flag in baud mode, or used the slow divider there, would show a wrong flag or a wrong count at the expected wrap cycle. A capture that paused the counter, or a wrong synchroniser depth, would put the count one step off against the cycle-exact reference model, which runs through directed and randomised control and pin patterns.

// File: rtl/crb_pkg.sv
package crb_pkg;
  typedef enum logic [1:0] {
    MODE_RELOAD  = 2'd0,
    MODE_CAPTURE = 2'd1,
    MODE_BAUD    = 2'd2
  } crb_mode_e;

  function automatic crb_mode_e decode_mode(input logic tx_sel, input logic rx_sel,
                                            input logic cap_sel);
    if (tx_sel || rx_sel) return MODE_BAUD;
    else if (cap_sel)     return MODE_CAPTURE;
    else                  return MODE_RELOAD;
  endfunction
endpackage

// File: rtl/crb_edge.sv
module crb_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic fall_o
);
  // [0..STAGES-1] synchroniser, [STAGES] previous synchronised level
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '1;
    else         sh_q <= {sh_q[STAGES-1:0], pin_i};
  end

  assign fall_o = sh_q[STAGES] & ~sh_q[STAGES-1];
endmodule

// File: rtl/crb_prescale.sv
module crb_prescale #(
  parameter int DIV_TMR  = 12,
  parameter int DIV_BAUD = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic fast_i,
  output logic tick_o
);
  localparam int PW = (DIV_TMR > 1) ? $clog2(DIV_TMR) : 1;
  localparam logic [PW-1:0] TMR_TOP  = PW'(DIV_TMR - 1);
  localparam logic [PW-1:0] BAUD_TOP = PW'(DIV_BAUD - 1);

  logic [PW-1:0] pre_q;
  logic [PW-1:0] top;

  assign top    = fast_i ? BAUD_TOP : TMR_TOP;
  // >= so a switch to the short divider never strands the count above top
  assign tick_o = run_i && (pre_q >= top);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pre_q <= '0;
    else if (!run_i)  pre_q <= '0;
    else if (tick_o)  pre_q <= '0;
    else              pre_q <= pre_q + 1'b1;
  end

  assert_no_back_to_back_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/crb_counter.sv
module crb_counter
  import crb_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  crb_mode_e    mode_i,
  input  logic         cnt_en_i,
  input  logic         trig_i,
  input  logic         cnt_wr_i,
  input  logic [W-1:0] cnt_data_i,
  input  logic         rld_wr_i,
  input  logic [W-1:0] rld_data_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] rld_o,
  output logic         ovf_o
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt_q, rld_q;
  logic         do_reload, do_capture;

  assign ovf_o      = cnt_en_i && (cnt_q == CNT_MAX);
  assign do_reload  = (ovf_o && mode_i != MODE_CAPTURE) || (trig_i && mode_i == MODE_RELOAD);
  assign do_capture = trig_i && mode_i == MODE_CAPTURE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (cnt_wr_i)   cnt_q <= cnt_data_i;
    else if (do_reload)  cnt_q <= rld_q;
    else if (cnt_en_i)   cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         rld_q <= '0;
    else if (rld_wr_i)   rld_q <= rld_data_i;
    else if (do_capture) rld_q <= cnt_q;
  end

  assign cnt_o = cnt_q;
  assign rld_o = rld_q;

  assert_capture_keeps_running_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_CAPTURE && trig_i && cnt_en_i && !cnt_wr_i && cnt_q != CNT_MAX)
    |=> cnt_q == $past(cnt_q) + 1'b1);

  assert_reload_on_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && mode_i != MODE_CAPTURE && !cnt_wr_i) |=> cnt_q == $past(rld_q));
endmodule

// File: rtl/crb_timer.sv
module crb_timer
  import crb_pkg::*;
#(
  parameter int W           = 16,
  parameter int DIV_TMR     = 12,
  parameter int DIV_BAUD    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         ext_src_i,
  input  logic         trig_en_i,
  input  logic         cap_sel_i,
  input  logic         tx_baud_i,
  input  logic         rx_baud_i,
  input  logic         cnt_pin_i,
  input  logic         trig_pin_i,
  input  logic         cnt_wr_i,
  input  logic [W-1:0] cnt_data_i,
  input  logic         rld_wr_i,
  input  logic [W-1:0] rld_data_i,
  input  logic         ovf_clr_i,
  input  logic         trig_clr_i,
  output logic [W-1:0] count_o,
  output logic [W-1:0] rld_o,
  output logic         ovf_flag_o,
  output logic         trig_flag_o,
  output logic         ovf_tick_o,
  output logic         tx_tick_o,
  output logic         rx_tick_o
);
  crb_mode_e mode;
  logic      baud, int_tick, cnt_fall, trig_fall, trig_evt, cnt_en, ovf;
  logic      ovf_flag_q, trig_flag_q, ovf_tick_q, tx_tick_q, rx_tick_q;

  assign mode = decode_mode(tx_baud_i, rx_baud_i, cap_sel_i);
  assign baud = (mode == MODE_BAUD);

  crb_edge #(.STAGES(SYNC_STAGES)) u_cnt_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(cnt_pin_i), .fall_o(cnt_fall));

  crb_edge #(.STAGES(SYNC_STAGES)) u_trig_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(trig_pin_i), .fall_o(trig_fall));

  crb_prescale #(.DIV_TMR(DIV_TMR), .DIV_BAUD(DIV_BAUD)) u_prescale (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i), .fast_i(baud), .tick_o(int_tick));

  assign cnt_en   = run_i && (ext_src_i ? cnt_fall : int_tick);
  assign trig_evt = trig_en_i && trig_fall;

  crb_counter #(.W(W)) u_counter (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode), .cnt_en_i(cnt_en), .trig_i(trig_evt),
    .cnt_wr_i(cnt_wr_i), .cnt_data_i(cnt_data_i), .rld_wr_i(rld_wr_i),
    .rld_data_i(rld_data_i), .cnt_o(count_o), .rld_o(rld_o), .ovf_o(ovf));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_flag_q  <= 1'b0;
      trig_flag_q <= 1'b0;
      ovf_tick_q  <= 1'b0;
      tx_tick_q   <= 1'b0;
      rx_tick_q   <= 1'b0;
    end else begin
      // set wins over clear
      ovf_flag_q  <= (ovf && !baud) || (ovf_flag_q && !ovf_clr_i);
      trig_flag_q <= trig_evt || (trig_flag_q && !trig_clr_i);
      ovf_tick_q  <= ovf;
      tx_tick_q   <= ovf && tx_baud_i;
      rx_tick_q   <= ovf && rx_baud_i;
    end
  end

  assign ovf_flag_o  = ovf_flag_q;
  assign trig_flag_o = trig_flag_q;
  assign ovf_tick_o  = ovf_tick_q;
  assign tx_tick_o   = tx_tick_q;
  assign rx_tick_o   = rx_tick_q;

  assert_no_ovf_flag_in_baud_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_flag_o) |-> $past(mode != MODE_BAUD));

  assert_serial_tick_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_tick_o || rx_tick_o) |-> ovf_tick_o);

  assert_stopped_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !cnt_wr_i && !trig_evt) |=> $stable(count_o));

  assert_single_tick_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_tick_o && !$past(cnt_wr_i)) |-> count_o != $past(count_o));
endmodule

// File: tb/crb_timer_tb.sv
`timescale 1ns/1ps
module crb_timer_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        run = 0, ext_src = 0, trig_en = 0, cap_sel = 0, tx_b = 0, rx_b = 0;
  logic        cnt_pin = 1, trig_pin = 1, cnt_wr = 0, rld_wr = 0, ovf_clr = 0, trig_clr = 0;
  logic [15:0] cnt_data = 0, rld_data = 0;
  logic [15:0] count, rld;
  logic        ovf_flag, trig_flag, ovf_tick, tx_tick, rx_tick;

  int    n_checks = 0, n_errors = 0;
  string cur_tag  = "R1";
  bit    done     = 0;

  always #5 clk = ~clk;

  crb_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .ext_src_i(ext_src), .trig_en_i(trig_en),
    .cap_sel_i(cap_sel), .tx_baud_i(tx_b), .rx_baud_i(rx_b), .cnt_pin_i(cnt_pin),
    .trig_pin_i(trig_pin), .cnt_wr_i(cnt_wr), .cnt_data_i(cnt_data), .rld_wr_i(rld_wr),
    .rld_data_i(rld_data), .ovf_clr_i(ovf_clr), .trig_clr_i(trig_clr), .count_o(count),
    .rld_o(rld), .ovf_flag_o(ovf_flag), .trig_flag_o(trig_flag), .ovf_tick_o(ovf_tick),
    .tx_tick_o(tx_tick), .rx_tick_o(rx_tick));

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          m_pre;
  logic [15:0] m_cnt, m_rld;
  bit          m_of, m_tf, m_ot, m_tt, m_rt;
  bit          cq[$], tq[$];   // pin samples, oldest first, three deep

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pre = 0; m_cnt = 0; m_rld = 0;
      m_of = 0; m_tf = 0; m_ot = 0; m_tt = 0; m_rt = 0;
      cq = '{1, 1, 1}; tq = '{1, 1, 1};
    end else begin
      bit is_baud, is_cap, itick, cfall, tfall, en, wrap, trig;
      int top;
      logic [15:0] n_cnt, n_rld;
      is_baud = tx_b || rx_b;
      is_cap  = !is_baud && cap_sel;
      top     = is_baud ? 1 : 11;
      itick   = run && (m_pre >= top);
      cfall   = cq[0] && !cq[1];
      tfall   = tq[0] && !tq[1];
      en      = run && (ext_src ? cfall : itick);
      wrap    = en && (m_cnt == 16'hFFFF);
      trig    = trig_en && tfall;
      n_cnt = m_cnt;
      if (cnt_wr) n_cnt = cnt_data;
      else if ((wrap && !is_cap) || (trig && !is_cap && !is_baud)) n_cnt = m_rld;
      else if (en) n_cnt = m_cnt + 16'd1;
      n_rld = m_rld;
      if (rld_wr) n_rld = rld_data;
      else if (trig && is_cap) n_rld = m_cnt;
      m_of  = (wrap && !is_baud) || (m_of && !ovf_clr);
      m_tf  = trig || (m_tf && !trig_clr);
      m_ot  = wrap;
      m_tt  = wrap && tx_b;
      m_rt  = wrap && rx_b;
      m_cnt = n_cnt;
      m_rld = n_rld;
      m_pre = !run ? 0 : (itick ? 0 : m_pre + 1);
      void'(cq.pop_front()); cq.push_back(cnt_pin);
      void'(tq.pop_front()); tq.push_back(trig_pin);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(cur_tag, "model count", count, m_cnt);
      check(cur_tag, "model rld", rld, m_rld);
      check(cur_tag, "model flags", {ovf_flag, trig_flag}, {m_of, m_tf});
      check(cur_tag, "model ticks", {ovf_tick, tx_tick, rx_tick}, {m_ot, m_tt, m_rt});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cnt(logic [15:0] v);
    cnt_data = v; cnt_wr = 1; step(1); cnt_wr = 0;
  endtask

  task automatic wr_rld(logic [15:0] v);
    rld_data = v; rld_wr = 1; step(1); rld_wr = 0;
  endtask

  task automatic clr_flags();
    ovf_clr = 1; trig_clr = 1; step(1); ovf_clr = 0; trig_clr = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    // R1 reset state
    check("R1", "count", count, 0);
    check("R1", "rld", rld, 0);
    check("R1", "flags+ticks", {ovf_flag, trig_flag, ovf_tick, tx_tick, rx_tick}, 0);

    // R10 direct write
    cur_tag = "R10";
    wr_cnt(16'h0100);
    check("R10", "count write", count, 16'h0100);

    // R4 stopped counter holds
    cur_tag = "R4";
    step(50);
    check("R4", "stopped count", count, 16'h0100);

    // R3 internal divide by 12 in auto-reload mode
    cur_tag = "R3";
    run = 1; step(36); run = 0;
    check("R3", "div12 count", count, 16'h0103);

    // R5 wrap reloads and sets flag, R11 tick
    cur_tag = "R5";
    wr_rld(16'h1234);
    wr_cnt(16'hFFFE);
    run = 1; step(24); run = 0;
    check("R5", "reloaded count", count, 16'h1234);
    check("R5", "ovf flag", ovf_flag, 1);
    check("R11", "ovf tick", ovf_tick, 1);
    step(1);
    check("R11", "tick one cycle", ovf_tick, 0);

    // R9 clear
    cur_tag = "R9";
    ovf_clr = 1; step(1); ovf_clr = 0;
    check("R9", "ovf flag cleared", ovf_flag, 0);

    // R6 trigger reload while stopped
    cur_tag = "R6";
    trig_en = 1;
    wr_cnt(16'h5555);
    trig_pin = 0; step(2);
    check("R6", "not yet reloaded", count, 16'h5555);
    step(1);
    check("R6", "trigger reload", count, 16'h1234);
    check("R6", "trig flag", trig_flag, 1);
    trig_pin = 1; step(3);
    clr_flags();

    // R6 trigger ignored with enable off
    trig_en = 0;
    wr_cnt(16'h5555);
    trig_pin = 0; step(5);
    check("R6", "disabled trigger count", count, 16'h5555);
    check("R6", "disabled trigger flag", trig_flag, 0);
    trig_pin = 1; step(3);

    // R7 capture
    cur_tag = "R7";
    cap_sel = 1; trig_en = 1;
    wr_cnt(16'h0ABC);
    trig_pin = 0; step(3);
    check("R7", "captured value", rld, 16'h0ABC);
    check("R7", "count untouched", count, 16'h0ABC);
    trig_pin = 1; step(3);
    clr_flags();
    wr_cnt(16'hFFFF);
    run = 1; step(12); run = 0;
    check("R7", "capture wrap to zero", count, 16'h0000);
    check("R7", "capture ovf flag", ovf_flag, 1);
    check("R7", "rld kept", rld, 16'h0ABC);
    clr_flags();

    // R8 baud mode, cap_sel still 1 (R2)
    cur_tag = "R8";
    tx_b = 1;
    wr_rld(16'hFFFD);
    wr_cnt(16'hFFFD);
    run = 1; step(6);
    check("R8", "baud reload", count, 16'hFFFD);
    check("R8", "tx/rx tick", {tx_tick, rx_tick}, 2'b10);
    check("R8", "no ovf flag", ovf_flag, 0);
    check("R11", "baud ovf tick", ovf_tick, 1);
    tx_b = 0; rx_b = 1; step(6); run = 0;
    check("R8", "rx tick", {tx_tick, rx_tick}, 2'b01);

    // R2 capture bit ignored in baud mode
    cur_tag = "R2";
    trig_pin = 0; step(3);
    check("R2", "no capture in baud", rld, 16'hFFFD);
    check("R2", "no reload in baud", count, 16'hFFFD);
    check("R6", "trig flag in baud", trig_flag, 1);
    trig_pin = 1; step(3);
    clr_flags();

    // R3 external source, auto-reload
    cur_tag = "R3";
    rx_b = 0; cap_sel = 0; ext_src = 1;
    wr_cnt(16'h0010);
    run = 1;
    for (int i = 0; i < 2; i++) begin
      cnt_pin = 0; step(3);
      cnt_pin = 1; step(3);
    end
    run = 0;
    check("R3", "external count", count, 16'h0012);
    ext_src = 0;

    // randomised phase, reference model compares every cycle
    cur_tag = "R2";
    for (int c = 0; c < 4000; c++) begin
      if (c % 200 == 0) begin
        {run, ext_src, trig_en, cap_sel} = 4'($urandom);
        tx_b = ($urandom % 3 == 0);
        rx_b = ($urandom % 3 == 0);
        run  = run | ($urandom % 2 == 0);
      end
      if ($urandom % 3 == 0) cnt_pin = ~cnt_pin;
      if ($urandom % 5 == 0) trig_pin = ~trig_pin;
      ovf_clr  = ($urandom % 16 == 0);
      trig_clr = ($urandom % 16 == 0);
      cnt_wr   = ($urandom % 64 == 0);
      rld_wr   = ($urandom % 64 == 0);
      cnt_data = {8'hFF, 8'($urandom)};
      rld_data = {8'hFF, 8'($urandom)};
      step(1);
    end
    cnt_wr = 0; rld_wr = 0; ovf_clr = 0; trig_clr = 0;
    step(2);
    finish_run();
  end
endmodule